// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block receives configuration words over a write-only three-pin serial link: a serial clock, a serial data line and a latch strobe. Each rising serial clock edge appends one data bit to a frame register, most significant bit first. When the latch strobe rises, the three lowest bits of the frame, which are the last bits shifted, select one of five configuration registers. The upper bits of the frame are then copied into that register.

All three pins are asynchronous to the system clock. Each is brought into the system clock domain through a two-stage synchronizer, and its edges are detected there. For this reason the system clock must run at least four times faster than the serial clock. The five register values are driven out continuously. A one-cycle update pulse marks the register that has just been written, so that downstream logic can pick up the new setting. The frame register empties when the latch strobe falls, and each new frame starts from zero.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, all five configuration registers read zero and no update pulse is high.
- R2: Each rising serial clock edge, while the latch strobe is low, appends the data pin to the frame. Bits arrive most significant first. In a 32-bit frame, bits 31..3 form the 29-bit payload and bits 2..0 form the select code.
- R3: Select codes 0 to 4 write the payload into register 0 to 4. These are, in order: fraction/integer, phase, modulus/reference, function and clock divider. Register i appears on `cfg_o[i*29 +: 29]`.
- R4: Select codes 5, 6 and 7 are ignored. No register changes and no update pulse is raised.
- R5: A valid latch raises exactly one update pulse, on the bit of the written register, for one cycle. The pulse appears in the cycle after the latch edge is detected, together with the new register value. At most one update bit is high at a time.
- R6: A frame shorter than 32 bits leaves the missing upper payload bits at zero, because the frame register is cleared when the latch strobe falls.
- R7: A frame longer than 32 bits uses only the last 32 bits shifted.
- R8: Serial clock edges while the latch strobe is high do not shift, and they cause no further transfer.
- R9: A register keeps its value in every cycle without its update pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Latch strobe, asynchronous; rising edge transfers the frame |
| cfg_o | output | 145 | Five 29-bit register values, register i at bits i*29 +: 29 |
| upd_o | output | 5 | One-cycle update pulse per register |

## Verification
The assertions take the following for granted about the inputs:
- Each serial clock phase and each latch strobe pulse lasts several system cycles, so the latch level is still high when the update pulse appears.
- Serial data is stable around each serial clock rise.
- The latch strobe never falls in the same cycle as a serial clock rise.

The bench stays within these limits. It holds every serial clock phase for four system cycles and changes data only while the serial clock is low. It keeps the latch strobe high for at least six cycles and lets it fall only with the serial clock low. It then waits for the pipeline to settle before sampling.

// File: rtl/cfg_load_pkg.sv
// Shared constants and the destination register encoding for the serial
// configuration loader. Assumes the select code is three bits wide.
package cfg_load_pkg;
    localparam int FRAME_BITS = 32;
    localparam int SEL_BITS   = 3;
    localparam int DEST_COUNT = 5;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [2:0] {
        DEST_FRAC_INT = 3'd0,
        DEST_PHASE    = 3'd1,
        DEST_MOD_REF  = 3'd2,
        DEST_FUNC     = 3'd3,
        DEST_CLK_DIV  = 3'd4
    } dest_sel_e;
endpackage

// File: rtl/cfg_pin_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flip-flops
// into the clk domain. Assumes the bits are independent asynchronous levels.
module cfg_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Purpose: move each pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_frame.sv
// Frame register: appends one bit on each shift enable, MSB first, and
// clears on request. Assumes clear and shift are never wanted together;
// clear wins if they are.
module cfg_shift_frame #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_i,
    input  logic                  bit_i,
    input  logic                  clear_i,
    output logic [FRAME_BITS-1:0] frame_o
);
    // Purpose: clear or shift the frame register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            frame_o <= '0;
        end else if (shift_i) begin
            frame_o <= {frame_o[FRAME_BITS-2:0], bit_i};
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
// Destination register bank: on a load, writes the payload into the
// register whose index equals the select code and raises its update pulse
// for one cycle. Codes at or above DEST_COUNT match nothing and are ignored.
module cfg_reg_bank #(
    parameter int DEST_COUNT = 5,
    parameter int SEL_BITS   = 3,
    parameter int DATA_BITS  = 29
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic [SEL_BITS-1:0]             sel_i,
    input  logic [DATA_BITS-1:0]            data_i,
    output logic [DEST_COUNT*DATA_BITS-1:0] cfg_o,
    output logic [DEST_COUNT-1:0]           upd_o
);
    for (genvar g = 0; g < DEST_COUNT; g++) begin : g_dest
        logic hit;
        assign hit = load_i && (sel_i == SEL_BITS'(g));

        // Purpose: hold one register and emit its update pulse on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g*DATA_BITS +: DATA_BITS] <= '0;
                upd_o[g]                        <= 1'b0;
            end else begin
                upd_o[g] <= hit;
                if (hit) cfg_o[g*DATA_BITS +: DATA_BITS] <= data_i;
            end
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
// Serial configuration loader top. It synchronizes the three serial pins,
// detects serial clock and latch edges in the clk domain, shifts frames and
// transfers them into the register bank on a latch rise. Assumes clk is at
// least four times the serial clock rate.
module cfg_serial_loader
    import cfg_load_pkg::*;
#(
    parameter int FRAME_BITS_P = FRAME_BITS,
    parameter int SEL_BITS_P   = SEL_BITS,
    parameter int DEST_COUNT_P = DEST_COUNT,
    parameter int SYNC_DEPTH_P = SYNC_DEPTH,
    localparam int DATA_BITS   = FRAME_BITS_P - SEL_BITS_P
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ser_clk_i,
    input  logic                              ser_data_i,
    input  logic                              ser_le_i,
    output logic [DEST_COUNT_P*DATA_BITS-1:0] cfg_o,
    output logic [DEST_COUNT_P-1:0]           upd_o
);
    localparam int PIN_CLK  = 0;
    localparam int PIN_DATA = 1;
    localparam int PIN_LE   = 2;

    logic [2:0] pin_lvl;
    logic       sclk_prev, le_prev;
    logic       sclk_rise, le_rise, le_fall, le_lvl;
    logic [FRAME_BITS_P-1:0] frame;

    cfg_pin_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH_P)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le_i, ser_data_i, ser_clk_i}),
        .level_o (pin_lvl)
    );

    // Purpose: remember last synchronized clock and latch levels for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            le_prev   <= 1'b0;
        end else begin
            sclk_prev <= pin_lvl[PIN_CLK];
            le_prev   <= pin_lvl[PIN_LE];
        end
    end

    assign le_lvl    = pin_lvl[PIN_LE];
    assign sclk_rise = pin_lvl[PIN_CLK] & ~sclk_prev;
    assign le_rise   = le_lvl & ~le_prev;
    assign le_fall   = ~le_lvl & le_prev;

    cfg_shift_frame #(.FRAME_BITS(FRAME_BITS_P)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sclk_rise & ~le_lvl),
        .bit_i   (pin_lvl[PIN_DATA]),
        .clear_i (le_fall),
        .frame_o (frame)
    );

    cfg_reg_bank #(
        .DEST_COUNT (DEST_COUNT_P),
        .SEL_BITS   (SEL_BITS_P),
        .DATA_BITS  (DATA_BITS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (le_rise),
        .sel_i  (frame[SEL_BITS_P-1:0]),
        .data_i (frame[FRAME_BITS_P-1:SEL_BITS_P]),
        .cfg_o  (cfg_o),
        .upd_o  (upd_o)
    );
endmodule

// File: rtl/cfg_serial_loader_chk.sv
// Checker for the serial configuration loader, bound to the top module.
// Assumes latch pulses last longer than the synchronizer plus one cycle.
module cfg_serial_loader_chk #(
    parameter int DEST_COUNT = 5,
    parameter int SEL_BITS   = 3,
    parameter int DATA_BITS  = 29
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            le_lvl,
    input logic                            le_rise,
    input logic [SEL_BITS-1:0]             sel,
    input logic [DEST_COUNT*DATA_BITS-1:0] cfg,
    input logic [DEST_COUNT-1:0]           upd
);
    logic armed;

    // Purpose: exclude the first cycle after reset from history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd)); // R5
    AST_UPD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (|upd) |=> !(|upd)); // R5
    AST_UPD_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (|upd) |-> ($past(le_rise) && le_lvl)); // R5
    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && (int'(sel) >= DEST_COUNT)) |=> !(|upd)); // R4
    AST_HOLD_WITHOUT_UPD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !(|upd) |-> $stable(cfg)); // R9
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
    .DEST_COUNT (DEST_COUNT_P),
    .SEL_BITS   (SEL_BITS_P),
    .DATA_BITS  (DATA_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .le_lvl  (le_lvl),
    .le_rise (le_rise),
    .sel     (frame[SEL_BITS_P-1:0]),
    .cfg     (cfg_o),
    .upd     (upd_o)
);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
    import cfg_load_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PHASE_CYC  = 4;
    localparam int DB         = FRAME_BITS - SEL_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [DEST_COUNT*DB-1:0] cfg;
    logic [DEST_COUNT-1:0]    upd;

    int n_total = 0, n_fail = 0;
    bit finished = 1'b0;
    int upd_cnt [DEST_COUNT];
    int exp_cnt [DEST_COUNT];
    logic [DB-1:0] exp_reg [DEST_COUNT];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .ser_le_i(ser_le), .cfg_o(cfg), .upd_o(upd)
    );

    // count update pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n) for (int i = 0; i < DEST_COUNT; i++) if (upd[i]) upd_cnt[i]++;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(input logic b);
        ser_data = b;
        wait_cyc(PHASE_CYC);
        ser_clk = 1'b1;
        wait_cyc(PHASE_CYC);
        ser_clk = 1'b0;
    endtask

    task automatic shift_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
    endtask

    task automatic latch(input int extra);
        ser_le = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < extra; i++) ser_bit(1'b1);
        ser_le = 1'b0;
        wait_cyc(8);
    endtask

    task automatic model_write(input int code, input logic [DB-1:0] d);
        if (code < DEST_COUNT) begin
            exp_reg[code] = d;
            exp_cnt[code]++;
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < DEST_COUNT; i++) begin
            check(cfg[i*DB +: DB] == exp_reg[i], req, 64'(cfg[i*DB +: DB]), 64'(exp_reg[i]));
            check(upd_cnt[i] == exp_cnt[i], {req, " update count"}, 64'(upd_cnt[i]), 64'(exp_cnt[i]));
        end
    endtask

    function automatic logic [DB-1:0] pattern(input int p, input int code);
        case (p)
            0: return {DB{1'b1}};
            1: return '0;
            2: return DB'(29'h15555555 >> code);
            default: return DB'((code + 1) * 32'h0123_4567);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEST_COUNT; i++) begin
            upd_cnt[i] = 0;
            exp_cnt[i] = 0;
            exp_reg[i] = '0;
        end
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        // R1: reset state
        check(upd == '0, "R1 update pulses", 64'(upd), 64'd0);
        check_all("R1");

        // R2 R3 R4 R5: every select code with several payload patterns
        for (int code = 0; code < 8; code++) begin
            for (int p = 0; p < 4; p++) begin
                logic [DB-1:0] d;
                d = pattern(p, code);
                shift_bits(64'({d, 3'(code)}), FRAME_BITS);
                latch(0);
                model_write(code, d);
                check_all(code < DEST_COUNT ? "R2 R3 R5 sweep" : "R4 ignored code");
            end
        end

        // R3: named destination, clock divider register
        shift_bits(64'({29'h1234567, DEST_CLK_DIV}), FRAME_BITS);
        latch(0);
        model_write(4, 29'h1234567);
        check_all("R3 clock divider");

        // R6: short frame after a full one leaves upper payload bits zero
        shift_bits(64'({29'h1FFFFFFF, DEST_PHASE}), FRAME_BITS);
        latch(0);
        model_write(1, 29'h1FFFFFFF);
        shift_bits(64'({8'hB5, DEST_PHASE}), 11);
        latch(0);
        model_write(1, 29'h00000B5);
        check_all("R6 short frame");

        // R7: long frame keeps only the last 32 bits
        shift_bits({24'd0, 8'hFF, 29'h0ABCDEF1, DEST_MOD_REF}, 40);
        latch(0);
        model_write(2, 29'h0ABCDEF1);
        check_all("R7 long frame");

        // R8: serial clocks during latch high neither shift nor transfer again
        shift_bits(64'({29'h0F0F0F0, DEST_FUNC}), FRAME_BITS);
        latch(5);
        model_write(3, 29'h0F0F0F0);
        check_all("R8 clocks under latch");
        shift_bits(64'({2'b11, DEST_FUNC}), 5);
        latch(0);
        model_write(3, 29'h3);
        check_all("R8 fresh frame after latch");

        // R9: idle serial clocks without a latch change nothing
        shift_bits(64'({29'h1ABCDEF, DEST_FRAC_INT}), FRAME_BITS);
        wait_cyc(20);
        check_all("R9 no latch");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule